// File: doc/BRIEF.md
# Low-Power DDR Start-Up Command Sequencer

This block sits on the controller side of a low-power DDR memory and brings the device from a cold start to a state in which rows can be opened. After reset it keeps the clock enable high and sends only idle commands for a long, programmable settling window. It then issues a fixed series of commands: close all banks, refresh twice, program the standard mode register, program the extended mode register. Each command is followed by its own programmable wait. When the last wait ends, a ready flag rises and stays high.

Once ready, a refresh interval timer takes over. It counts clock cycles to one refresh slot, which is a 64 ms window divided into 4096 rows (15.625 µs), converted to cycles from a clock-frequency parameter in MHz. The number of refreshes still owed is kept in a small counter that saturates at eight. The scheduler downstream may therefore defer refreshes without losing any. Each cycle with the acknowledge input high retires one owed refresh. The refresh request and acknowledge are plain level control pins and carry no data, so there is no back-pressure rule. The mode-register codes are taken unchanged from input ports. All command pins come from registers, so they change only just after a rising clock edge.

Top module: `lpddr_init_seq`

## Requirements
- R1: While reset is low, the outputs are DESELECT (all four command pins high) with clock enable high, address and bank zero, ready low, refresh request low and owed count zero.
- R2: After reset is released, the command pins carry only NOP (select low, the other three high) or DESELECT until the bank-close command, which appears exactly HOLD_CYC rising edges after the release.
- R3: The sequence holds exactly five commands, in this order: close-all (pins 0010 as select, row, column, write strobes), refresh (0001), refresh (0001), mode load (0000), mode load (0000). After these, only NOP appears.
- R4: The close-all command drives address bit 10 high and all other address bits low.
- R5: The spacing in rising edges is TRP_CYC from close-all to the first refresh, TRFC_CYC from each refresh to the next command, and TMRD_CYC from the first mode load to the second.
- R6: The first mode load drives bank address 00 and address = the standard mode code input. The second drives bank address 10 (bit 1 high, bit 0 low) and address = the extended mode code input. The codes pass through unchanged: burst length in bits 2:0, burst type in bit 3, CAS latency in bits 6:4.
- R7: Ready rises exactly TMRD_CYC edges after the second mode load. It then stays high until reset, and only NOP is sent while it is high.
- R8: The refresh slot is REF_CYC = CLK_MHZ*15625/1000 cycles (integer division). The first owed refresh appears REF_CYC edges after ready rises, and later ones follow every REF_CYC edges. The owed count stays zero before ready.
- R9: The owed count rises by one per slot and falls by one for each edge at which the acknowledge input is high. It holds at 8 when a slot ends while it is full. An acknowledge at zero is ignored. A slot end and an acknowledge at the same edge leave the count unchanged. The request output is high exactly when the count is nonzero.
- R10: Clock enable is high on every cycle.
- R11: A reset part-way through the sequence clears all progress, and the whole sequence then restarts from the settling window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs change after its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mr_code | input | ADDR_W | Standard mode register code |
| emr_code | input | ADDR_W | Extended mode register code |
| ref_ack | input | 1 | Retires one owed refresh per cycle held high |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| addr | output | ADDR_W | Memory address bus |
| ba | output | 2 | Bank address |
| init_done | output | 1 | Start-up complete |
| ref_req | output | 1 | At least one refresh owed |
| ref_pending | output | PEND_W | Number of refreshes owed |

## Verification
The bound checker watches, on every cycle, the properties that need no timeline. Clock enable stays high, and every command uses a legal pin code. The close-all command carries bit 10. Mode loads use bank 00 or 10 only. Ready is sticky, and only NOP follows it. The owed count never exceeds eight, moves by at most one per edge, and stays zero before ready. Only the directed scenarios can show the exact command order and edge spacing, and the settling length. They also cover the first-slot and periodic refresh timing, saturation, an acknowledge colliding with a slot end or arriving at zero, and the restart after a mid-sequence reset.

// File: rtl/lpddr_init_pkg.sv
package lpddr_init_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111,
    CMD_DES = 4'b1111
  } cmd_e;

  typedef enum logic [2:0] {
    ST_PRE,
    ST_REF_A,
    ST_REF_B,
    ST_MRS,
    ST_EMRS,
    ST_DONE
  } step_e;

  localparam int ALL_BANK_BIT = 10;

  function automatic int max_of4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/lpddr_wait_ctr.sv
module lpddr_wait_ctr #(
  parameter int W = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt <= RST_VAL;
    else if (load)            cnt <= load_val;
    else if (en && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/lpddr_init_fsm.sv
module lpddr_init_fsm
  import lpddr_init_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 16,
  parameter int TRP_CYC  = 3,
  parameter int TRFC_CYC = 15,
  parameter int TMRD_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mr_code,
  input  logic [ADDR_W-1:0] emr_code,
  input  logic              ctr_zero,
  output logic              ctr_load,
  output logic [CNT_W-1:0]  ctr_val,
  output cmd_e              cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        ba,
  output logic              done
);
  step_e step;

  // wait after the command issued in the current step, minus one
  always_comb begin
    unique case (step)
      ST_PRE:            ctr_val = CNT_W'(TRP_CYC - 1);
      ST_REF_A, ST_REF_B: ctr_val = CNT_W'(TRFC_CYC - 1);
      ST_MRS, ST_EMRS:   ctr_val = CNT_W'(TMRD_CYC - 1);
      default:           ctr_val = '0;
    endcase
  end

  assign ctr_load = ctr_zero && (step != ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step <= ST_PRE;
      cmd  <= CMD_DES;
      addr <= '0;
      ba   <= '0;
      done <= 1'b0;
    end else begin
      cmd  <= CMD_NOP;
      addr <= '0;
      ba   <= '0;
      if (ctr_zero) begin
        unique case (step)
          ST_PRE: begin
            cmd <= CMD_PRE;
            addr[ALL_BANK_BIT] <= 1'b1;
            step <= ST_REF_A;
          end
          ST_REF_A: begin
            cmd  <= CMD_REF;
            step <= ST_REF_B;
          end
          ST_REF_B: begin
            cmd  <= CMD_REF;
            step <= ST_MRS;
          end
          ST_MRS: begin
            cmd  <= CMD_LMR;
            addr <= mr_code;
            ba   <= 2'b00;
            step <= ST_EMRS;
          end
          ST_EMRS: begin
            cmd  <= CMD_LMR;
            addr <= emr_code;
            ba   <= 2'b10;
            step <= ST_DONE;
          end
          default: done <= 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/lpddr_ref_timer.sv
module lpddr_ref_timer #(
  parameter int CLK_MHZ  = 200,
  parameter int PEND_MAX = 8,
  parameter int PEND_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ack,
  output logic [PEND_W-1:0] pending,
  output logic              req
);
  // 64 ms / 4096 rows = 15.625 us per slot
  localparam int REF_CYC = (CLK_MHZ * 15625) / 1000;
  localparam int RW      = $clog2(REF_CYC + 1);

  logic slot_zero, tick, inc, dec;

  lpddr_wait_ctr #(.W(RW), .RST_VAL(RW'(REF_CYC - 1))) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .load     (tick),
    .load_val (RW'(REF_CYC - 1)),
    .zero     (slot_zero)
  );

  assign tick = slot_zero && en;
  assign inc  = tick && (pending != PEND_W'(PEND_MAX));
  assign dec  = ack && (pending != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)          pending <= '0;
    else if (inc && !dec) pending <= pending + 1'b1;
    else if (dec && !inc) pending <= pending - 1'b1;
  end

  assign req = (pending != '0);
endmodule

// File: rtl/lpddr_init_seq.sv
module lpddr_init_seq
  import lpddr_init_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int CLK_MHZ  = 200,
  parameter int HOLD_CYC = 40000,
  parameter int TRP_CYC  = 3,
  parameter int TRFC_CYC = 15,
  parameter int TMRD_CYC = 2,
  parameter int PEND_MAX = 8,
  parameter int PEND_W   = $clog2(PEND_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mr_code,
  input  logic [ADDR_W-1:0] emr_code,
  input  logic              ref_ack,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        ba,
  output logic              init_done,
  output logic              ref_req,
  output logic [PEND_W-1:0] ref_pending
);
  localparam int MAX_WAIT = max_of4(HOLD_CYC, TRP_CYC, TRFC_CYC, TMRD_CYC);
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  logic             ctr_zero, ctr_load;
  logic [CNT_W-1:0] ctr_val;
  cmd_e             cmd;

  lpddr_wait_ctr #(.W(CNT_W), .RST_VAL(CNT_W'(HOLD_CYC - 1))) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (1'b1),
    .load     (ctr_load),
    .load_val (ctr_val),
    .zero     (ctr_zero)
  );

  lpddr_init_fsm #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .TRP_CYC(TRP_CYC), .TRFC_CYC(TRFC_CYC), .TMRD_CYC(TMRD_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .mr_code  (mr_code),
    .emr_code (emr_code),
    .ctr_zero (ctr_zero),
    .ctr_load (ctr_load),
    .ctr_val  (ctr_val),
    .cmd      (cmd),
    .addr     (addr),
    .ba       (ba),
    .done     (init_done)
  );

  lpddr_ref_timer #(.CLK_MHZ(CLK_MHZ), .PEND_MAX(PEND_MAX), .PEND_W(PEND_W)) u_ref (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (init_done),
    .ack     (ref_ack),
    .pending (ref_pending),
    .req     (ref_req)
  );

  assign cke = 1'b1;
  assign {cs_n, ras_n, cas_n, we_n} = cmd;
endmodule

// File: rtl/lpddr_init_seq_chk.sv
module lpddr_init_seq_chk #(
  parameter int ADDR_W   = 12,
  parameter int PEND_MAX = 8,
  parameter int PEND_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        ba,
  input logic              init_done,
  input logic [PEND_W-1:0] ref_pending
);
  logic [3:0] c;
  assign c = {cs_n, ras_n, cas_n, we_n};

  p_cke_high_r10: assert property (@(posedge clk) disable iff (!rst_n) cke);

  p_legal_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    c inside {4'b1111, 4'b0111, 4'b0010, 4'b0001, 4'b0000});

  p_pre_all_banks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0010) |-> addr[10]);

  p_mode_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0000) |-> (ba == 2'b00 || ba == 2'b10));

  p_ready_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  p_nop_after_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (c == 4'b0111));

  p_idle_before_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (ref_pending == '0));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pending <= PEND_W'(PEND_MAX));

  p_unit_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pending == $past(ref_pending)) ||
    (ref_pending == $past(ref_pending) + 1'b1) ||
    (ref_pending == $past(ref_pending) - 1'b1));
endmodule

bind lpddr_init_seq lpddr_init_seq_chk #(
  .ADDR_W(ADDR_W), .PEND_MAX(PEND_MAX), .PEND_W(PEND_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba),
  .init_done(init_done), .ref_pending(ref_pending)
);

// File: tb/lpddr_init_seq_test.sv
module lpddr_init_seq_test;
  localparam int AW   = 12;
  localparam int MHZ  = 4;
  localparam int HOLD = 20;
  localparam int TRP  = 3;
  localparam int TRFC = 7;
  localparam int TMRD = 2;
  localparam int REFC = (MHZ * 15625) / 1000;
  localparam int E_PRE  = HOLD;
  localparam int E_REF1 = E_PRE + TRP;
  localparam int E_REF2 = E_REF1 + TRFC;
  localparam int E_MRS  = E_REF2 + TRFC;
  localparam int E_EMRS = E_MRS + TMRD;
  localparam int E_DONE = E_EMRS + TMRD;

  logic clk = 1'b0, rst_n = 1'b0, ref_ack = 1'b0;
  logic [AW-1:0] mr_code = '0, emr_code = '0;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done, ref_req;
  logic [AW-1:0] addr;
  logic [1:0] ba;
  logic [3:0] ref_pending;

  int n_chk = 0, n_bad = 0, k = 0;

  always #2 clk = ~clk;

  lpddr_init_seq #(
    .ADDR_W(AW), .CLK_MHZ(MHZ), .HOLD_CYC(HOLD), .TRP_CYC(TRP),
    .TRFC_CYC(TRFC), .TMRD_CYC(TMRD), .PEND_MAX(8)
  ) uut (
    .clk(clk), .rst_n(rst_n), .mr_code(mr_code), .emr_code(emr_code),
    .ref_ack(ref_ack), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba),
    .init_done(init_done), .ref_req(ref_req), .ref_pending(ref_pending)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic stp();
    @(negedge clk);
    k++;
  endtask

  task automatic run_to(input int t);
    while (k < t) stp();
  endtask

  // R1: outputs while reset is held
  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ref_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b1111, "R1", "deselect in reset",
        {cs_n, ras_n, cas_n, we_n}, 15);
    chk(cke && addr == '0 && ba == '0, "R1", "cke/addr/ba in reset",
        {cke, addr != '0, ba != '0}, 4);
    chk(!init_done && !ref_req && ref_pending == 0, "R1", "flags in reset",
        {init_done, ref_req, ref_pending}, 0);
    rst_n = 1'b1;
    k = 0;
  endtask

  // R2 R3 R4 R5 R6 R7 R10 R11
  task automatic run_init(input logic [AW-1:0] mr, input logic [AW-1:0] emr);
    int ek[8];
    logic [3:0] ec[8];
    logic [AW-1:0] ea[8];
    logic [1:0] eb[8];
    int ncmd = 0, done_k = -1, quiet_bad = 0, cke_bad = 0;
    mr_code = mr;
    emr_code = emr;
    do_reset();
    while (k < E_DONE + 3) begin
      stp();
      if (!cke) cke_bad++;
      if (!({cs_n, ras_n, cas_n, we_n} inside {4'b0111, 4'b1111})) begin
        if (ncmd < 8) begin
          ek[ncmd] = k; ec[ncmd] = {cs_n, ras_n, cas_n, we_n};
          ea[ncmd] = addr; eb[ncmd] = ba;
        end
        ncmd++;
        if (k < HOLD) quiet_bad++;
      end
      if (init_done && done_k < 0) done_k = k;
    end
    chk(cke_bad == 0, "R10", "cke low cycles", cke_bad, 0);
    chk(quiet_bad == 0, "R2", "commands inside hold", quiet_bad, 0);
    chk(ncmd == 5, "R3", "command count", ncmd, 5);
    if (ncmd == 5) begin
      chk(ek[0] == E_PRE, "R2", "close-all edge", ek[0], E_PRE);
      chk(ec[0] == 4'b0010 && ec[1] == 4'b0001 && ec[2] == 4'b0001 &&
          ec[3] == 4'b0000 && ec[4] == 4'b0000, "R3", "command order",
          {ec[0], ec[1], ec[2], ec[3], ec[4]}, 'h21100);
      chk(ea[0] == AW'(1 << 10), "R4", "close-all address", ea[0], 1 << 10);
      chk(ek[1] - ek[0] == TRP, "R5", "tRP spacing", ek[1] - ek[0], TRP);
      chk(ek[2] - ek[1] == TRFC, "R5", "tRFC spacing 1", ek[2] - ek[1], TRFC);
      chk(ek[3] - ek[2] == TRFC, "R5", "tRFC spacing 2", ek[3] - ek[2], TRFC);
      chk(ek[4] - ek[3] == TMRD, "R5", "tMRD spacing", ek[4] - ek[3], TMRD);
      chk(ea[3] == mr && eb[3] == 2'b00, "R6", "standard load addr/ba",
          {eb[3], ea[3]}, {2'b00, mr});
      chk(ea[4] == emr && eb[4] == 2'b10, "R6", "extended load addr/ba",
          {eb[4], ea[4]}, {2'b10, emr});
    end
    chk(done_k == E_DONE, "R7", "ready edge", done_k, E_DONE);
    chk(init_done, "R7", "ready held", init_done, 1);
  endtask

  // R8 R9
  task automatic run_refresh();
    run_to(E_DONE + 8);
    ref_ack = 1'b1; stp(); ref_ack = 1'b0;
    chk(ref_pending == 0 && !ref_req, "R9", "ack at zero ignored", ref_pending, 0);
    run_to(E_DONE + REFC - 1);
    chk(!ref_req, "R8", "no request before first slot", ref_req, 0);
    stp();
    chk(ref_req && ref_pending == 1, "R8", "first slot request", ref_pending, 1);
    run_to(E_DONE + 2 * REFC - 1);
    chk(ref_pending == 1, "R8", "count before second slot", ref_pending, 1);
    stp();
    chk(ref_pending == 2, "R8", "second slot", ref_pending, 2);
    run_to(E_DONE + 8 * REFC);
    chk(ref_pending == 8, "R9", "count reaches 8", ref_pending, 8);
    run_to(E_DONE + 9 * REFC + 1);
    chk(ref_pending == 8, "R9", "saturated at 8", ref_pending, 8);
    ref_ack = 1'b1; repeat (3) stp(); ref_ack = 1'b0;
    chk(ref_pending == 5, "R9", "three acks", ref_pending, 5);
    run_to(E_DONE + 10 * REFC - 1);
    ref_ack = 1'b1; stp(); ref_ack = 1'b0;
    chk(ref_pending == 5, "R9", "ack with slot end", ref_pending, 5);
    ref_ack = 1'b1; repeat (6) stp(); ref_ack = 1'b0;
    chk(ref_pending == 0 && !ref_req, "R9", "drained, extra ack ignored",
        ref_pending, 0);
    run_to(E_DONE + 11 * REFC);
    chk(ref_pending == 1 && ref_req, "R9", "request after drain", ref_pending, 1);
  endtask

  // R11: reset part-way, then full restart
  task automatic run_midreset();
    do_reset();
    run_to(HOLD + TRP + 2);
    run_init(12'h02C, 12'h061);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    run_init(12'h032, 12'h020);
    run_refresh();
    run_midreset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule